// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a small synchronous SRAM whose inputs are registered on the rising clock edge and whose read path has no output register: once an edge has loaded or advanced the address, the addressed word reaches `data_out` combinationally in that same cycle. A two-bit burst counter lets one loaded address serve four consecutive beats inside an aligned four-word block. The beat order is linear or interleaved, chosen by an order-select input when the address is loaded.

Two active-low address strobes can start a burst. The processor strobe counts only while the chip enable is low, and it always makes that cycle a read. The controller strobe always counts, and it honours the write controls. Writes may cover the whole word through a global write, or single bytes through a byte-write enable and four byte selects. A strobe that arrives while any chip select is inactive deselects the device, and its output goes high-impedance after that single edge. An asynchronous output enable gates the drivers. An asynchronous sleep input turns the drivers off and blocks writes, and the memory contents are kept. The bidirectional data bus is split into `data_in`, `data_out` and `data_oe`.

The controller has four named states. `ST_DESEL` means deselected, and reset enters it. `ST_READ` is an active read beat. `ST_WRITE` is an active write beat. `ST_SLEEP` is power-down. The transitions are: T_SLEEP (any state goes to `ST_SLEEP` while `sleep` is high), T_WAKE (`ST_SLEEP` goes to `ST_DESEL` once `sleep` is low), T_DESELECT (a valid strobe while not fully selected goes to `ST_DESEL`), T_LOAD_READ (a valid processor strobe, or a controller strobe with no write, goes to `ST_READ`), T_LOAD_WRITE (a controller strobe with a write goes to `ST_WRITE`), T_CONTINUE (no strobe in `ST_READ` or `ST_WRITE` goes to `ST_WRITE` if a write is requested, otherwise to `ST_READ`, and the counter steps when `advance_n` is low), and T_STAY (no strobe in `ST_DESEL` stays there).

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, the block stays in `ST_DESEL` with `data_oe` low, until a strobe arrives.
- R2: Address and control are sampled on the rising edge. After a load edge, `data_out` shows the word at the loaded address in that same cycle, and `data_oe` is high when `out_en_n` is low.
- R3: With `lin_order`=1 at load, the beats after the first use low address bits (start+k) mod 4, for k=1,2,3, each taken on an edge with `advance_n` low.
- R4: With `lin_order`=0 at load, the beats after the first use low address bits start XOR k, for k=1,2,3.
- R5: After the fourth beat, one more advance returns to the start address inside the same four-word block. With `advance_n` high and no strobe, the address stays the same.
- R6: `proc_strobe_n` low has no effect while `chip_en_n` is high.
- R7: A processor-strobe load is always a read. `wr_all_n`, `byte_wr_en_n` and `byte_sel_n` are ignored on that edge.
- R8: A controller-strobe load with `wr_all_n` low writes all 32 bits of `data_in` to the loaded address, and `data_oe` stays low in that write beat.
- R9: With `wr_all_n` high and `byte_wr_en_n` low, only the byte lanes whose `byte_sel_n[i]` is low are written (lane i is bits 8i+7..8i). `wr_all_n` low overrides the byte selects. Continuation beats write to the advanced address.
- R10: A valid strobe (the controller strobe, or the processor strobe with `chip_en_n` low) while `chip_en_n` is high, `sel_a` is low or `sel_b_n` is high deselects the block, and `data_oe` is low from the next cycle on.
- R11: `out_en_n` high forces `data_oe` low at once, without a clock edge.
- R12: While `sleep` is high, `data_oe` is low and no write takes effect. Memory contents are kept, and after `sleep` falls the block stays deselected until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | ADDR_W | Word address loaded by a strobe |
| chip_en_n | input | 1 | Active-low chip enable; also qualifies the processor strobe |
| sel_a | input | 1 | Active-high chip select |
| sel_b_n | input | 1 | Active-low chip select |
| proc_strobe_n | input | 1 | Processor address strobe, active low, read-only load |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, load honouring writes |
| advance_n | input | 1 | Active-low burst advance |
| lin_order | input | 1 | Burst order captured at load: 1 linear, 0 interleaved |
| wr_all_n | input | 1 | Active-low global write of all bytes |
| byte_wr_en_n | input | 1 | Active-low enable for the byte selects |
| byte_sel_n | input | BYTES | Active-low per-lane write selects |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous active-high power-down |
| data_in | input | BYTES*8 | Write data |
| data_out | output | BYTES*8 | Flow-through read data |
| data_oe | output | 1 | Output driver enable for the data bus |

## Verification
The assertions check on every cycle that the output enable and sleep gate the drivers, that reset keeps the bus quiet, that a deselecting strobe, a global-write load or a processor-strobe load has the right effect on the drivers one edge later, and that a held address with no write keeps `data_out` stable. The memory contents seen through `data_out` can only be shown by the bench's scenarios: the linear and interleaved beat orders and their wrap, masked byte writes and their override, write controls being ignored on processor loads, and contents surviving sleep.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sbs_state_e;

    localparam int BURST_W = 2;

    // Low address bits of a beat: linear adds, interleaved XORs.
    function automatic logic [BURST_W-1:0] beat_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               linear
    );
        logic [BURST_W-1:0] r;
        if (linear) r = start + beat;
        else        r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/sbs_burst_counter.sv
`timescale 1ns/1ps
module sbs_burst_counter
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_linear,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q, base_d;
    logic [BURST_W-1:0] beat_q, beat_d;
    logic               lin_q,  lin_d;

    always_comb begin
        base_d = base_q;
        beat_d = beat_q;
        lin_d  = lin_q;
        if (load) begin
            base_d = load_addr;
            beat_d = '0;
            lin_d  = load_linear;
        end else if (step) begin
            beat_d = beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            lin_q  <= 1'b1;
        end else begin
            base_q <= base_d;
            beat_q <= beat_d;
            lin_q  <= lin_d;
        end
    end

    assign cur_addr  = {base_q[ADDR_W-1 -: HI_W],
                        beat_low(base_q[BURST_W-1:0], beat_q, lin_q)};
    assign next_addr = {base_d[ADDR_W-1 -: HI_W],
                        beat_low(base_d[BURST_W-1:0], beat_d, lin_d)};

endmodule

// File: rtl/sbs_write_decode.sv
`timescale 1ns/1ps
module sbs_write_decode #(
    parameter int BYTES = 4
) (
    input  logic             wr_all_n,
    input  logic             byte_wr_en_n,
    input  logic [BYTES-1:0] byte_sel_n,
    input  logic             allow,
    output logic [BYTES-1:0] lane_we,
    output logic             wr_req
);

    logic [BYTES-1:0] raw;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign raw[g]     = !wr_all_n || (!byte_wr_en_n && !byte_sel_n[g]);
        assign lane_we[g] = raw[g] && allow;
    end

    assign wr_req = |raw;

endmodule

// File: rtl/sbs_mem_array.sv
`timescale 1ns/1ps
module sbs_mem_array #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic [BYTES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/sbs_ctrl.sv
`timescale 1ns/1ps
module sbs_ctrl
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    input  logic       chip_en_n,
    input  logic       sel_a,
    input  logic       sel_b_n,
    input  logic       proc_strobe_n,
    input  logic       ctrl_strobe_n,
    input  logic       advance_n,
    input  logic       wr_req,
    output logic       load,
    output logic       step,
    output logic       wr_allow,
    output logic       drive,
    output sbs_state_e state
);

    sbs_state_e state_q, state_d;
    logic       selected, proc_valid, strobe;

    assign selected   = !chip_en_n && sel_a && !sel_b_n;
    assign proc_valid = !proc_strobe_n && !chip_en_n;
    assign strobe     = proc_valid || !ctrl_strobe_n;

    // Next state and counter / write controls.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        step     = 1'b0;
        wr_allow = 1'b0;
        if (sleep) begin
            state_d = ST_SLEEP;                       // T_SLEEP
        end else begin
            unique case (state_q)
                ST_SLEEP: state_d = ST_DESEL;         // T_WAKE
                ST_DESEL, ST_READ, ST_WRITE: begin
                    if (strobe) begin
                        if (!selected) begin
                            state_d = ST_DESEL;       // T_DESELECT
                        end else if (proc_valid) begin
                            load    = 1'b1;
                            state_d = ST_READ;        // T_LOAD_READ
                        end else begin
                            load     = 1'b1;
                            wr_allow = 1'b1;
                            state_d  = wr_req ? ST_WRITE : ST_READ; // T_LOAD_WRITE / T_LOAD_READ
                        end
                    end else if (state_q == ST_DESEL) begin
                        state_d = ST_DESEL;           // T_STAY
                    end else begin
                        step     = !advance_n;
                        wr_allow = 1'b1;
                        state_d  = wr_req ? ST_WRITE : ST_READ; // T_CONTINUE
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        drive = 1'b0;
        unique case (state_q)
            ST_READ:                      drive = 1'b1;
            ST_DESEL, ST_WRITE, ST_SLEEP: drive = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               chip_en_n,
    input  logic               sel_a,
    input  logic               sel_b_n,
    input  logic               proc_strobe_n,
    input  logic               ctrl_strobe_n,
    input  logic               advance_n,
    input  logic               lin_order,
    input  logic               wr_all_n,
    input  logic               byte_wr_en_n,
    input  logic [BYTES-1:0]   byte_sel_n,
    input  logic               out_en_n,
    input  logic               sleep,
    input  logic [BYTES*8-1:0] data_in,
    output logic [BYTES*8-1:0] data_out,
    output logic               data_oe
);

    localparam int BYTE_W = 8;

    logic              load, step, wr_allow, drive, wr_req;
    logic [BYTES-1:0]  lane_we;
    logic [ADDR_W-1:0] cur_addr, next_addr;
    sbs_state_e        state;

    sbs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .chip_en_n(chip_en_n), .sel_a(sel_a), .sel_b_n(sel_b_n),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .advance_n(advance_n), .wr_req(wr_req),
        .load(load), .step(step), .wr_allow(wr_allow),
        .drive(drive), .state(state)
    );

    sbs_write_decode #(.BYTES(BYTES)) u_wdec (
        .wr_all_n(wr_all_n), .byte_wr_en_n(byte_wr_en_n),
        .byte_sel_n(byte_sel_n), .allow(wr_allow),
        .lane_we(lane_we), .wr_req(wr_req)
    );

    sbs_burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .load_addr(addr_i), .load_linear(lin_order),
        .cur_addr(cur_addr), .next_addr(next_addr)
    );

    sbs_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk(clk), .lane_we(lane_we), .waddr(next_addr), .wdata(data_in),
        .raddr(cur_addr), .rdata(data_out)
    );

    assign data_oe = drive && !out_en_n && !sleep && (state == ST_READ);

endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
module sbs_checker #(
    parameter int BYTES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chip_en_n,
    input logic               sel_a,
    input logic               sel_b_n,
    input logic               proc_strobe_n,
    input logic               ctrl_strobe_n,
    input logic               advance_n,
    input logic               wr_all_n,
    input logic               byte_wr_en_n,
    input logic               out_en_n,
    input logic               sleep,
    input logic [BYTES*8-1:0] data_out,
    input logic               data_oe
);

    logic selected, proc_valid, strobe;
    assign selected   = !chip_en_n && sel_a && !sel_b_n;
    assign proc_valid = !proc_strobe_n && !chip_en_n;
    assign strobe     = proc_valid || !ctrl_strobe_n;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !data_oe);

    p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !data_oe);

    p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !data_oe);

    p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !selected && !sleep) |=> !data_oe);

    p_write_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !proc_valid && selected && !wr_all_n && !sleep) |=> !data_oe);

    p_proc_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_valid && selected && !sleep) |=> (sleep || out_en_n || data_oe));

    // R5 hold; also covers R6 (processor strobe with chip enable high is no strobe)
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && data_oe && advance_n && ctrl_strobe_n && !proc_valid
         && wr_all_n && byte_wr_en_n)
        |=> (sleep || out_en_n || (data_oe && $stable(data_out))));

endmodule

bind sync_burst_sram sbs_checker #(.BYTES(BYTES)) u_sbs_checker (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .sel_a(sel_a),
    .sel_b_n(sel_b_n), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n),
    .wr_all_n(wr_all_n), .byte_wr_en_n(byte_wr_en_n),
    .out_en_n(out_en_n), .sleep(sleep), .data_out(data_out),
    .data_oe(data_oe)
);

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;

    localparam int AW = 6;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          chip_en_n, sel_a, sel_b_n, proc_strobe_n, ctrl_strobe_n;
    logic          advance_n, lin_order, wr_all_n, byte_wr_en_n;
    logic [NB-1:0] byte_sel_n;
    logic          out_en_n, sleep;
    logic [31:0]   data_in, data_out;
    logic          data_oe;

    int errors = 0;
    int checks = 0;
    logic [31:0] ref_mem [64];

    always #2.5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .BYTES(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .chip_en_n(chip_en_n),
        .sel_a(sel_a), .sel_b_n(sel_b_n), .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n),
        .lin_order(lin_order), .wr_all_n(wr_all_n),
        .byte_wr_en_n(byte_wr_en_n), .byte_sel_n(byte_sel_n),
        .out_en_n(out_en_n), .sleep(sleep), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F00;
    endfunction

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        chip_en_n = 0; sel_a = 1; sel_b_n = 0;
        proc_strobe_n = 1; ctrl_strobe_n = 1; advance_n = 1;
        wr_all_n = 1; byte_wr_en_n = 1; byte_sel_n = 4'hF;
        out_en_n = 0; sleep = 0; data_in = '0;
    endtask

    task automatic proc_load(input int a, input logic lin);
        idle();
        proc_strobe_n = 0; addr_i = AW'(a); lin_order = lin;
        tick();
        idle();
    endtask

    task automatic t_reset;
        idle(); rst_n = 0; addr_i = '0; lin_order = 1;
        repeat (3) tick();
        chk1("R1 oe in reset", data_oe, 1'b0);
        rst_n = 1;
        tick();
        chk1("R1 oe after reset", data_oe, 1'b0);
    endtask

    task automatic t_fill;
        for (int a = 0; a < 32; a++) begin
            idle();
            ctrl_strobe_n = 0; wr_all_n = 0; addr_i = AW'(a); data_in = pat(a);
            tick();
            ref_mem[a] = pat(a);
            if (a == 5) chk1("R8 write beat oe", data_oe, 1'b0);
        end
        idle();
        for (int a = 0; a < 32; a += 7) begin
            proc_load(a, 1'b1);
            chk1("R2 oe on load", data_oe, 1'b1);
            chk32("R2 flow-through data", data_out, ref_mem[a]);
        end
    endtask

    task automatic t_burst(input int start, input logic lin, input string tag);
        int base;
        int lo;
        base = start & ~3;
        proc_load(start, lin);
        chk32({tag, " beat0"}, data_out, ref_mem[start]);
        for (int k = 1; k <= 4; k++) begin
            advance_n = 0;
            tick();
            lo = lin ? ((start + k) & 3) : ((start & 3) ^ (k & 3));
            chk32({tag, (k == 4) ? " R5 wrap" : " beat"}, data_out, ref_mem[base + lo]);
        end
        idle();
        tick();
        chk32("R5 hold with advance high", data_out, ref_mem[start]);
    endtask

    task automatic t_proc_ignored;
        proc_load(3, 1'b1);
        proc_strobe_n = 0; chip_en_n = 1; addr_i = AW'(12);
        tick();
        idle();
        chk1("R6 oe kept", data_oe, 1'b1);
        chk32("R6 address kept", data_out, ref_mem[3]);
    endtask

    task automatic t_proc_read;
        idle();
        proc_strobe_n = 0; addr_i = AW'(20); wr_all_n = 0; byte_wr_en_n = 0;
        byte_sel_n = 4'h0; data_in = 32'hDEAD_BEEF; lin_order = 1;
        tick();
        idle();
        chk1("R7 read beat oe", data_oe, 1'b1);
        chk32("R7 no write", data_out, ref_mem[20]);
        tick();
        chk32("R7 memory unchanged", data_out, ref_mem[20]);
    endtask

    task automatic t_byte_write;
        idle();
        ctrl_strobe_n = 0; addr_i = AW'(24); lin_order = 1;
        byte_wr_en_n = 0; byte_sel_n = 4'b1010; data_in = 32'h1122_3344;
        tick();
        ref_mem[24] = (ref_mem[24] & 32'hFF00_FF00) | (32'h1122_3344 & 32'h00FF_00FF);
        chk1("R9 write beat oe", data_oe, 1'b0);
        idle();
        advance_n = 0; byte_wr_en_n = 0; byte_sel_n = 4'b0111; data_in = 32'h9988_7766;
        tick();
        ref_mem[25] = (ref_mem[25] & 32'h00FF_FFFF) | 32'h9900_0000;
        idle();
        advance_n = 0; wr_all_n = 0; byte_wr_en_n = 0; byte_sel_n = 4'hF;
        data_in = 32'hCAFE_F00D;
        tick();
        ref_mem[26] = 32'hCAFE_F00D;
        proc_load(24, 1'b1);
        chk32("R9 masked lanes", data_out, ref_mem[24]);
        advance_n = 0; tick();
        chk32("R9 continuation lane", data_out, ref_mem[25]);
        advance_n = 0; tick();
        chk32("R9 global overrides selects", data_out, ref_mem[26]);
        idle();
    endtask

    task automatic t_deselect;
        proc_load(5, 1'b1);
        chk1("R10 active before", data_oe, 1'b1);
        ctrl_strobe_n = 0; sel_a = 0;
        tick();
        idle();
        chk1("R10 deselect via sel_a", data_oe, 1'b0);
        tick();
        chk1("R10 stays deselected", data_oe, 1'b0);
        proc_load(5, 1'b1);
        proc_strobe_n = 0; sel_b_n = 1;
        tick();
        idle();
        chk1("R10 deselect via sel_b_n", data_oe, 1'b0);
    endtask

    task automatic t_oe;
        proc_load(6, 1'b1);
        out_en_n = 1; #0.5;
        chk1("R11 oe gated", data_oe, 1'b0);
        out_en_n = 0; #0.5;
        chk1("R11 oe restored", data_oe, 1'b1);
    endtask

    task automatic t_sleep;
        proc_load(7, 1'b1);
        sleep = 1; #0.5;
        chk1("R12 sleep gates oe", data_oe, 1'b0);
        ctrl_strobe_n = 0; wr_all_n = 0; addr_i = AW'(7); data_in = 32'h0BAD_0BAD;
        tick();
        idle(); sleep = 1;
        tick();
        sleep = 0;
        tick();
        chk1("R12 deselected after wake", data_oe, 1'b0);
        proc_load(7, 1'b1);
        chk32("R12 contents kept", data_out, ref_mem[7]);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_burst(6, 1'b1, "R3 linear");
        t_burst(9, 1'b0, "R4 interleaved");
        t_burst(15, 1'b0, "R4 interleaved high");
        t_proc_ignored();
        t_proc_read();
        t_byte_write();
        t_deselect();
        t_oe();
        t_sleep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule